// File: doc/BRIEF.md
# External Data Access Controller

This block sits between an 8-bit CPU core and the memory behind its external-data move instructions. Each byte request names an access width: a short 8-bit register-indirect address or a full 16-bit pointer address. The block then sends the request either to a small on-chip auxiliary RAM or to an external multiplexed address/data bus, and it generates that bus's address-latch strobe and its active-low write and read pulses. Requests come in on a valid/ready handshake. `req_ready` is high only when no external cycle is in flight. A request is taken on any clock edge where `req_valid` and `req_ready` are both high. While `req_ready` is low the requester must hold or withdraw its request, and the block does not look at it. Completion is a one-cycle `done` pulse with no back-pressure, and `rsp_rdata` is valid in that cycle for reads.

Four control inputs set the routing and timing. A routing bit forces every access to the external bus. Two size bits set how much of the on-chip RAM is enabled, so external devices can take the addresses above it. A stretch bit lengthens the bus pulses for slow peripherals. The on-chip RAM array itself lives outside the block and is reached through a synchronous port.

Top module: `xdata_ctrl`

## Requirements
- R1: When `cfg_ext_only` is 1, every accepted request runs as an external bus cycle and `aux_en` stays 0.
- R2: When `cfg_ext_only` is 0 and the effective address is below the enabled size, the request goes on chip. In the acceptance cycle `aux_en` is 1, with `aux_we` = `req_write`. `done` is 1 in the following cycle, and for reads `rsp_rdata` then carries the RAM's output.
- R3: An on-chip access leaves `lo_out`, `lo_oe`, `hi_out`, `addr_latch`, `bus_wr_n` and `bus_rd_n` unchanged.
- R4: When `cfg_ext_only` is 0 and the effective address is at or above the enabled size, the request runs as an external bus cycle.
- R5: When `req_wide` is 0 the effective address is `{8'h00, req_addr[7:0]}`, and bits 15:8 of `req_addr` are ignored. In that mode an external cycle puts only `req_addr[7:0]` on `lo_out`, and `hi_out` keeps its previous value.
- R6: When `req_wide` is 1, `hi_out` shows `req_addr[15:8]` from the cycle after acceptance to the end of the cycle and keeps it afterwards. `lo_out` shows `req_addr[7:0]` with `lo_oe` = 1 during the address and hold cycles.
- R7: An external cycle proceeds in a fixed order. First comes one address cycle with `addr_latch` = 1, in the cycle after acceptance. Next comes one hold cycle with `addr_latch` = 0 and both strobes high. Then the strobe pulse starts.
- R8: On an external write, `bus_wr_n` is 0 for the whole pulse, and `lo_oe` = 1 with `lo_out` = the accepted write data throughout. `bus_rd_n` stays 1.
- R9: On an external read, `bus_rd_n` is 0 for the whole pulse and `lo_oe` is 0. `rsp_rdata` in the `done` cycle equals `lo_in` as sampled on the last clock of the pulse, and `done` comes in the cycle after the pulse ends.
- R10: The strobe pulse lasts 6 clocks when `cfg_stretch` is 0 at acceptance and 30 clocks when it is 1.
- R11: The enabled on-chip size is (`cfg_size`+1)×256 bytes (00 = 256, 01 = 512, 10 = 768, 11 = 1024). `aux_addr` equals the low 10 bits of the effective address.
- R12: `req_ready` is 0 from the cycle after an external acceptance until the `done` cycle. Requests presented in that window have no effect on the bus or on the result.
- R13: After reset `addr_latch` = 0, both strobes = 1, `lo_oe` = 0, `hi_out` = 8'hFF, `done` = 0 and `req_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_ext_only | input | 1 | 1 sends all accesses to the external bus |
| cfg_size | input | 2 | Enabled on-chip size, in 256-byte pages minus one |
| cfg_stretch | input | 1 | 1 selects 30-clock strobes, 0 selects 6 |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 write, 0 read |
| req_wide | input | 1 | 1 for 16-bit pointer address, 0 for 8-bit indirect |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write data |
| done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read data, valid with done |
| aux_en | output | 1 | On-chip RAM access enable |
| aux_we | output | 1 | On-chip RAM write enable |
| aux_addr | output | 10 | On-chip RAM address |
| aux_wdata | output | 8 | On-chip RAM write data |
| aux_rdata | input | 8 | On-chip RAM read data, one cycle after enable |
| lo_out | output | 8 | Low bus port output: address then data |
| lo_oe | output | 1 | Low bus port output enable |
| lo_in | input | 8 | Low bus port input |
| hi_out | output | 8 | High bus port: upper address byte |
| addr_latch | output | 1 | Address latch strobe, active high |
| bus_wr_n | output | 1 | External write strobe, active low |
| bus_rd_n | output | 1 | External read strobe, active low |

## Verification
Some rules are checked on every cycle: the strobes are never low together, the latch strobe is a single cycle that never overlaps a strobe, the bus port is driven during writes and released during reads, write data holds still under the write pulse, every strobe pulse lasts either 6 or 30 clocks, the handshake stays closed during a cycle, and an on-chip access leaves the bus pins quiet. Only the bench's sweeps can show the routing decision for each size, mode and width, the exact address and data bytes on the ports, the pulse length matching the stretch setting, the read sample taken on the last pulse clock, and requests presented while busy being ignored.

// File: rtl/xdc_pkg.sv
package xdc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADDR  = 2'd1,
    ST_HOLD  = 2'd2,
    ST_PULSE = 2'd3
  } bus_st_e;
endpackage

// File: rtl/xdc_route.sv
// Decides on-chip vs external and forms the on-chip RAM address.
module xdc_route #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int SEL_W  = 2
) (
  input  logic                    wide,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    ext_only,
  input  logic [SEL_W-1:0]        size_sel,
  output logic                    on_chip,
  output logic [DATA_W+SEL_W-1:0] aux_addr
);
  localparam int AUX_AW = DATA_W + SEL_W;

  logic [ADDR_W-1:0] eff;
  logic              top_zero;
  logic              page_ok;

  // narrow mode can only reach the first page
  always_comb eff = wide ? addr : {{(ADDR_W-DATA_W){1'b0}}, addr[DATA_W-1:0]};

  generate
    if (ADDR_W > AUX_AW) begin : g_top
      assign top_zero = (eff[ADDR_W-1:AUX_AW] == '0);
    end else begin : g_full
      assign top_zero = 1'b1;
    end
  endgenerate

  assign page_ok  = (eff[AUX_AW-1:DATA_W] <= size_sel);
  assign on_chip  = !ext_only && top_zero && page_ok;
  assign aux_addr = eff[AUX_AW-1:0];
endmodule

// File: rtl/xdc_pulse_timer.sv
// Down-counter that times the strobe pulse.
module xdc_pulse_timer #(
  parameter int SHORT = 6,
  parameter int LONG  = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic long_sel,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LONG + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= long_sel ? CW'(LONG - 1) : CW'(SHORT - 1);
    end else if (run && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/xdc_bus_seq.sv
// External bus cycle sequencer: address, hold, strobe pulse, completion.
module xdc_bus_seq #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     req_write,
  input  logic                     req_wide,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic                     req_stretch,
  input  logic [DATA_W-1:0]        lo_in,
  input  logic                     tmr_expired,
  output logic                     busy,
  output logic                     tmr_load,
  output logic                     tmr_long,
  output logic                     tmr_run,
  output logic                     latch,
  output logic                     wr_n,
  output logic                     rd_n,
  output logic [DATA_W-1:0]        lo_out,
  output logic                     lo_oe,
  output logic [ADDR_W-DATA_W-1:0] hi_out,
  output logic                     ext_done,
  output logic [DATA_W-1:0]        ext_rdata
);
  import xdc_pkg::*;

  bus_st_e           st;
  logic              wr_q;
  logic              str_q;
  logic [DATA_W-1:0] wd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      wr_q      <= 1'b0;
      str_q     <= 1'b0;
      wd_q      <= '0;
      latch     <= 1'b0;
      wr_n      <= 1'b1;
      rd_n      <= 1'b1;
      lo_out    <= '1;
      lo_oe     <= 1'b0;
      hi_out    <= '1;
      ext_done  <= 1'b0;
      ext_rdata <= '0;
    end else begin
      ext_done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            st     <= ST_ADDR;
            latch  <= 1'b1;
            lo_out <= req_addr[DATA_W-1:0];
            lo_oe  <= 1'b1;
            if (req_wide) hi_out <= req_addr[ADDR_W-1:DATA_W];
            wr_q   <= req_write;
            wd_q   <= req_wdata;
            str_q  <= req_stretch;
          end
        end
        ST_ADDR: begin
          latch <= 1'b0;
          st    <= ST_HOLD;
        end
        ST_HOLD: begin
          st <= ST_PULSE;
          if (wr_q) begin
            wr_n   <= 1'b0;
            lo_out <= wd_q;
          end else begin
            rd_n  <= 1'b0;
            lo_oe <= 1'b0;
          end
        end
        ST_PULSE: begin
          if (tmr_expired) begin
            wr_n     <= 1'b1;
            rd_n     <= 1'b1;
            lo_oe    <= 1'b0;
            ext_done <= 1'b1;
            if (!wr_q) ext_rdata <= lo_in;
            st       <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (st != ST_IDLE);
  assign tmr_load = (st == ST_HOLD);
  assign tmr_long = str_q;
  assign tmr_run  = (st == ST_PULSE);
endmodule

// File: rtl/xdata_ctrl.sv
// Routes CPU external-data byte accesses to on-chip RAM or the external bus.
module xdata_ctrl #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int SEL_W       = 2,
  parameter int PULSE_SHORT = 6,
  parameter int PULSE_LONG  = 30,
  localparam int AUX_AW     = DATA_W + SEL_W,
  localparam int HI_W       = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_ext_only,
  input  logic [SEL_W-1:0]  cfg_size,
  input  logic              cfg_stretch,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              aux_en,
  output logic              aux_we,
  output logic [AUX_AW-1:0] aux_addr,
  output logic [DATA_W-1:0] aux_wdata,
  input  logic [DATA_W-1:0] aux_rdata,
  output logic [DATA_W-1:0] lo_out,
  output logic              lo_oe,
  input  logic [DATA_W-1:0] lo_in,
  output logic [HI_W-1:0]   hi_out,
  output logic              addr_latch,
  output logic              bus_wr_n,
  output logic              bus_rd_n
);
  logic              on_chip;
  logic              accept;
  logic              start_ext;
  logic              busy;
  logic              int_done_q;
  logic              ext_done;
  logic [DATA_W-1:0] ext_rdata;
  logic              tmr_load;
  logic              tmr_long;
  logic              tmr_run;
  logic              tmr_expired;

  xdc_route #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_route (
    .wide     (req_wide),
    .addr     (req_addr),
    .ext_only (cfg_ext_only),
    .size_sel (cfg_size),
    .on_chip  (on_chip),
    .aux_addr (aux_addr)
  );

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign start_ext = accept && !on_chip;
  assign aux_en    = accept && on_chip;
  assign aux_we    = req_write;
  assign aux_wdata = req_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) int_done_q <= 1'b0;
    else        int_done_q <= accept && on_chip;
  end

  xdc_bus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start_ext),
    .req_write   (req_write),
    .req_wide    (req_wide),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .req_stretch (cfg_stretch),
    .lo_in       (lo_in),
    .tmr_expired (tmr_expired),
    .busy        (busy),
    .tmr_load    (tmr_load),
    .tmr_long    (tmr_long),
    .tmr_run     (tmr_run),
    .latch       (addr_latch),
    .wr_n        (bus_wr_n),
    .rd_n        (bus_rd_n),
    .lo_out      (lo_out),
    .lo_oe       (lo_oe),
    .hi_out      (hi_out),
    .ext_done    (ext_done),
    .ext_rdata   (ext_rdata)
  );

  xdc_pulse_timer #(.SHORT(PULSE_SHORT), .LONG(PULSE_LONG)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .long_sel(tmr_long),
    .run     (tmr_run),
    .expired (tmr_expired)
  );

  // completions of the two kinds never fall in the same cycle
  assign done      = int_done_q | ext_done;
  assign rsp_rdata = int_done_q ? aux_rdata : ext_rdata;
endmodule

// File: rtl/xdc_checker.sv
module xdc_checker #(
  parameter int DATA_W      = 8,
  parameter int HI_W        = 8,
  parameter int PULSE_SHORT = 6,
  parameter int PULSE_LONG  = 30
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_ext_only,
  input logic              req_ready,
  input logic              aux_en,
  input logic [DATA_W-1:0] lo_out,
  input logic              lo_oe,
  input logic [HI_W-1:0]   hi_out,
  input logic              addr_latch,
  input logic              bus_wr_n,
  input logic              bus_rd_n
);
  localparam int CW = $clog2(PULSE_LONG + 2) + 1;

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      low_cnt <= '0;
    else if (!bus_wr_n || !bus_rd_n) low_cnt <= low_cnt + 1'b1;
    else                             low_cnt <= '0;
  end

  AST_ROUTE_EXT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ext_only |-> !aux_en); // R1
  AST_ONCHIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    aux_en |=> ($stable(lo_out) && $stable(lo_oe) && $stable(hi_out) && bus_wr_n && bus_rd_n && !addr_latch)); // R3
  AST_LATCH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_latch |=> !addr_latch); // R7
  AST_LATCH_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_latch |-> (bus_wr_n && bus_rd_n)); // R7
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_wr_n && !bus_rd_n)); // R8
  AST_WR_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_n |-> lo_oe); // R8
  AST_WR_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr_n && !$past(bus_wr_n)) |-> $stable(lo_out)); // R8
  AST_RD_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> !lo_oe); // R9
  AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_wr_n) || $rose(bus_rd_n)) |-> (low_cnt == CW'(PULSE_SHORT) || low_cnt == CW'(PULSE_LONG))); // R10
  AST_BUSY_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_latch || !bus_wr_n || !bus_rd_n) |-> !req_ready); // R12
endmodule

bind xdata_ctrl xdc_checker #(
  .DATA_W(DATA_W), .HI_W(HI_W), .PULSE_SHORT(PULSE_SHORT), .PULSE_LONG(PULSE_LONG)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_ext_only(cfg_ext_only),
  .req_ready   (req_ready),
  .aux_en      (aux_en),
  .lo_out      (lo_out),
  .lo_oe       (lo_oe),
  .hi_out      (hi_out),
  .addr_latch  (addr_latch),
  .bus_wr_n    (bus_wr_n),
  .bus_rd_n    (bus_rd_n)
);

// File: tb/sim_xdata_ctrl.sv
module sim_xdata_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_ext_only = 1'b0;
  logic [1:0]  cfg_size = 2'd0;
  logic        cfg_stretch = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic        req_wide = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        done;
  logic [7:0]  rsp_rdata;
  logic        aux_en, aux_we;
  logic [9:0]  aux_addr;
  logic [7:0]  aux_wdata;
  logic [7:0]  aux_rdata;
  logic [7:0]  lo_out;
  logic        lo_oe;
  logic [7:0]  lo_in = '0;
  logic [7:0]  hi_out;
  logic        addr_latch, bus_wr_n, bus_rd_n;

  int checks = 0;
  int errors = 0;
  logic [7:0] ram [0:1023];
  logic [7:0] shadow [0:1023];
  logic [7:0] ram_q;
  logic [7:0] hi_exp = 8'hFF;

  always #10 clk = ~clk;

  xdata_ctrl u0 (.*);

  // stand-in for the on-chip RAM array: synchronous read
  always_ff @(posedge clk) begin
    if (aux_en) begin
      if (aux_we) ram[aux_addr] <= aux_wdata;
      else        ram_q <= ram[aux_addr];
    end
  end
  assign aux_rdata = ram_q;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic access(bit wr, bit wide, logic [15:0] a, logic [7:0] wd, bit stretch);
    logic [15:0] eff;
    bit          internal;
    int          len;
    logic [7:0]  val;
    logic [7:0]  lo0;
    logic        oe0;
    logic [7:0]  hi0;
    string       rt;
    eff      = wide ? a : {8'h00, a[7:0]};
    internal = !cfg_ext_only && (eff < (16'(cfg_size) + 16'd1) * 16'd256);
    len      = stretch ? 30 : 6;
    val      = a[15:8] ^ a[7:0] ^ 8'h96;
    rt       = internal ? "R2" : (cfg_ext_only ? "R1" : "R4");
    lo0 = lo_out; oe0 = lo_oe; hi0 = hi_out;
    cfg_stretch = stretch; req_write = wr; req_wide = wide;
    req_addr = a; req_wdata = wd; req_valid = 1'b1;
    #1;
    chk(rt, "route aux_en", int'(aux_en), int'(internal));
    chk("R12", "ready when idle", int'(req_ready), 1);
    if (internal) begin
      chk("R11", "aux_addr", int'(aux_addr), int'(eff[9:0]));
      chk("R2", "aux_we", int'(aux_we), int'(wr));
    end
    @(posedge clk); @(negedge clk);
    if (internal) begin
      req_valid = 1'b0;
      chk("R2", "done next cycle", int'(done), 1);
      if (!wr) chk("R2", "on-chip read data", int'(rsp_rdata), int'(shadow[eff[9:0]]));
      else     shadow[eff[9:0]] = wd;
      chk("R3", "lo_out held", int'(lo_out), int'(lo0));
      chk("R3", "lo_oe held", int'(lo_oe), int'(oe0));
      chk("R3", "hi_out held", int'(hi_out), int'(hi0));
      chk("R3", "strobes idle", int'({addr_latch, bus_wr_n, bus_rd_n}), 3);
      return;
    end
    // address cycle; present a conflicting request that must be ignored
    req_addr = a ^ 16'h5555; req_wdata = ~wd; req_write = !wr;
    if (wide) hi_exp = a[15:8];
    chk("R7", "latch high", int'(addr_latch), 1);
    chk(wide ? "R6" : "R5", "low address", int'(lo_out), int'(a[7:0]));
    chk(wide ? "R6" : "R5", "high port", int'(hi_out), int'(hi_exp));
    chk("R6", "address driven", int'(lo_oe), 1);
    chk("R12", "busy not ready", int'(req_ready), 0);
    chk("R12", "no early done", int'(done), 0);
    @(negedge clk);
    chk("R7", "hold cycle", int'({addr_latch, bus_wr_n, bus_rd_n}), 3);
    chk("R6", "address held", int'(lo_out), int'(a[7:0]));
    for (int k = 1; k <= len; k++) begin
      @(negedge clk);
      if (!wr) lo_in = (k == len) ? val : ~val;
      if (wr) begin
        chk("R8", "wr low", int'({bus_wr_n, bus_rd_n}), 1);
        chk("R8", "write data", int'(lo_out), int'(wd));
        chk("R8", "write drive", int'(lo_oe), 1);
      end else begin
        chk("R9", "rd low", int'({bus_wr_n, bus_rd_n}), 2);
        chk("R9", "read release", int'(lo_oe), 0);
      end
      chk(wide ? "R6" : "R5", "high port in pulse", int'(hi_out), int'(hi_exp));
      chk("R12", "ready low in pulse", int'(req_ready), 0);
    end
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10", "pulse ended", int'({bus_wr_n, bus_rd_n}), 3);
    chk("R10", "done after pulse", int'(done), 1);
    chk("R12", "ready at done", int'(req_ready), 1);
    if (!wr) chk("R9", "read sample", int'(rsp_rdata), int'(val));
    @(negedge clk);
    chk("R10", "single done", int'(done), 0);
  endtask

  initial begin
    logic [15:0] al [5];
    for (int i = 0; i < 1024; i++) begin
      ram[i] = 8'(i * 7 + 1);
      shadow[i] = 8'(i * 7 + 1);
    end
    repeat (3) @(negedge clk);
    chk("R13", "latch reset", int'(addr_latch), 0);
    chk("R13", "strobes reset", int'({bus_wr_n, bus_rd_n}), 3);
    chk("R13", "oe reset", int'(lo_oe), 0);
    chk("R13", "high port reset", int'(hi_out), 8'hFF);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13", "done reset", int'(done), 0);
    chk("R13", "ready reset", int'(req_ready), 1);
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        cfg_ext_only = m[0];
        cfg_size = 2'(s);
        al[0] = 16'h0000;
        al[1] = 16'(s * 256 + 255);
        al[2] = 16'((s + 1) * 256);
        al[3] = 16'h03FF;
        al[4] = 16'hA5C3;
        for (int i = 0; i < 5; i++) begin
          for (int w = 0; w < 2; w++) begin
            access(1'b1, w[0], al[i], al[i][7:0] ^ 8'h3C ^ 8'(s * 17), i == 2);
            access(1'b0, w[0], al[i], 8'h00, i == 2);
          end
        end
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule